// File: doc/BRIEF.md
# Host-to-Microcontroller Byte Mailbox

The mailbox couples a host bus to an 8-bit link toward a small controller. The host sees a 32-byte register window that holds three 32-bit registers: an interrupt register, a data register and a status register. Host writes to the data register queue one byte for the controller. Host reads of the data register take one byte that the controller has sent. Both directions are buffered by an 8-entry FIFO, and in both directions the byte travels in bits 15:8 of the data word.

On the controller side the block drives a byte stream with valid/ready handshaking and accepts an incoming byte stream with its own valid/ready pair. Each request flag is gated by its mask bit and the results are ORed onto a single interrupt line. Receive overflow is a sticky condition. The host clears pending conditions by writing back the status value it read, or by writing ones to the request bits of the interrupt register.

Top module: `mbx_host_mailbox`

## Requirements
- R1: After reset the status register reads 0x3, the interrupt register reads 0x0, `irq` and `tx_valid` are 0 and `rx_ready` is 1.
- R2: A host write to byte offset 0x4 queues `bus_wdata[15:8]` for the link, and the low byte of the word is ignored. Queued bytes leave on `tx_byte` in write order, one per cycle in which `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_byte` holds steady.
- R3: The transmit queue holds 8 bytes. A data write while it is full is dropped. Status bit 1 (transmit not full) reads 0 while 8 bytes are held.
- R4: An incoming byte is taken when `rx_valid` is high and the receive queue is not full. A host read of offset 0x4 returns the oldest byte in bits 15:8 with all other bits zero, and removes it. A take and a removal may happen in the same cycle.
- R5: A read of offset 0x4 while the receive queue is empty returns 0 and changes no state.
- R6: An incoming byte that arrives while the receive queue holds 8 bytes is discarded. It sets status bit 3 (overflow), which is sticky, and request bit 3. `rx_ready` is 0 while the queue is full.
- R7: Writing status offset 0x8 with a 1 in bit k clears request bit k, and a 1 in bit 3 also clears the overflow status. Zero bits have no effect. An overflow in the same cycle as its clear leaves overflow set.
- R8: Interrupt register bits 0 to 3 are request flags for transmit-empty, transmit-not-full, receive-not-empty and overflow. Bits 0 to 2 are set when the matching condition goes from false to true. Writing offset 0x0 stores bits 7:4 as the masks and clears every request bit written with 1.
- R9: `irq` is high exactly when some request bit and its mask bit (request bit + 4) are both set.
- R10: Offsets 0xC to 0x1C read as 0, and writes to them have no effect. Address bits 1:0 are ignored.
- R11: Status bits 0, 1 and 2 report, as live values, that the transmit queue is empty, that it is not full, and that the receive queue is not empty. The upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Byte available toward the controller |
| tx_ready | input | 1 | Controller accepts the byte |
| tx_byte | output | 8 | Byte toward the controller |
| rx_valid | input | 1 | Byte offered by the controller |
| rx_ready | output | 1 | Receive queue has room |
| rx_byte | input | 8 | Byte from the controller |

## Verification
Two collisions can occur in a single cycle. In the first, the controller overflows the receive queue in the same cycle as a host status write that clears overflow. The bench drives both on one edge with a full queue, and expects a status value of 0xF afterwards because the set wins. In the second, the host removes the only stored byte in the same cycle as the controller offers a new one. The bench expects the old byte to be returned in that cycle, the new byte to follow on the next read, and an empty read after that.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WIN_AW   = 5;
    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int BYTE_LSB = 8;
    localparam int NUM_REQ  = 4;

    localparam int IDX_TX_EMPTY = 0;
    localparam int IDX_TX_ROOM  = 1;
    localparam int IDX_RX_AVAIL = 2;
    localparam int IDX_RX_OVF   = 3;

    typedef enum logic [1:0] {
        SEL_IRQ,
        SEL_DATA,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_word(input logic [WIN_AW-3:0] word);
        case (word)
            3'd0:    decode_word = SEL_IRQ;
            3'd1:    decode_word = SEL_DATA;
            3'd2:    decode_word = SEL_STAT;
            default: decode_word = SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(cnt)); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (cnt == '0)); // R5
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int         NREQ     = 4,
    parameter logic [2:0] RST_COND = 3'b011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-2:0] cond_live,
    input  logic            ovf_evt,
    input  logic [NREQ-1:0] clr_req,
    input  logic            clr_ovf,
    input  logic            mask_we,
    input  logic [NREQ-1:0] mask_wd,
    output logic [NREQ-1:0] req_q,
    output logic [NREQ-1:0] mask_q,
    output logic            ovf_q,
    output logic            irq
);
    logic [NREQ-2:0] cond_prev;
    logic [NREQ-1:0] set_vec;

    generate
        for (genvar i = 0; i < NREQ - 1; i++) begin : g_edge
            assign set_vec[i] = cond_live[i] && !cond_prev[i];
        end
    endgenerate
    assign set_vec[NREQ-1] = ovf_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_prev <= RST_COND[NREQ-2:0];
            req_q     <= '0;
            mask_q    <= '0;
            ovf_q     <= 1'b0;
        end else begin
            cond_prev <= cond_live;
            req_q     <= set_vec | (req_q & ~clr_req);
            if (mask_we) mask_q <= mask_wd;
            ovf_q     <= ovf_evt || (ovf_q && !clr_ovf);
        end
    end

    assign irq = |(req_q & mask_q);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (ovf_q && req_q[NREQ-1])); // R6
    AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !ovf_evt) |=> !ovf_q); // R7
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q); // R6
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox
    import mbx_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_byte
);
    localparam int BYTE_MSB = BYTE_LSB + BYTE_W - 1;

    reg_sel_e             sel;
    logic                 wr_acc, rd_acc;
    logic                 tx_push, tx_pop, tx_empty, tx_full;
    logic                 rx_pop, rx_empty, rx_full, ovf_evt;
    logic [BYTE_W-1:0]    rx_head;
    logic [NUM_REQ-1:0]   status, req_q, mask_q, clr_req;
    logic                 ovf_q;
    logic                 unused_bits;

    assign unused_bits = ^{bus_wdata[BUS_W-1:BYTE_MSB+1], bus_addr[1:0]};

    assign sel    = decode_word(bus_addr[WIN_AW-1:2]);
    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    assign tx_push  = wr_acc && (sel == SEL_DATA);
    assign tx_valid = !tx_empty;
    assign tx_pop   = tx_valid && tx_ready;

    assign rx_pop   = rd_acc && (sel == SEL_DATA);
    assign rx_ready = !rx_full;
    assign ovf_evt  = rx_valid && rx_full;

    mbx_fifo #(.DW(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (bus_wdata[BYTE_MSB:BYTE_LSB]),
        .pop   (tx_pop),
        .dout  (tx_byte),
        .empty (tx_empty),
        .full  (tx_full)
    );

    mbx_fifo #(.DW(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .din   (rx_byte),
        .pop   (rx_pop),
        .dout  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_comb begin
        status               = '0;
        status[IDX_TX_EMPTY] = tx_empty;
        status[IDX_TX_ROOM]  = !tx_full;
        status[IDX_RX_AVAIL] = !rx_empty;
        status[IDX_RX_OVF]   = ovf_q;
    end

    always_comb begin
        clr_req = '0;
        if (wr_acc && (sel == SEL_STAT || sel == SEL_IRQ))
            clr_req = bus_wdata[NUM_REQ-1:0];
    end

    mbx_irq #(.NREQ(NUM_REQ), .RST_COND(3'b011)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_live (status[NUM_REQ-2:0]),
        .ovf_evt   (ovf_evt),
        .clr_req   (clr_req),
        .clr_ovf   (wr_acc && (sel == SEL_STAT) && bus_wdata[IDX_RX_OVF]),
        .mask_we   (wr_acc && (sel == SEL_IRQ)),
        .mask_wd   (bus_wdata[2*NUM_REQ-1:NUM_REQ]),
        .req_q     (req_q),
        .mask_q    (mask_q),
        .ovf_q     (ovf_q),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_IRQ:  bus_rdata[2*NUM_REQ-1:0] = {mask_q, req_q};
            SEL_DATA: if (!rx_empty) bus_rdata[BYTE_MSB:BYTE_LSB] = rx_head;
            SEL_STAT: bus_rdata[NUM_REQ-1:0] = status;
            SEL_NONE: bus_rdata = '0;
        endcase
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R2
    AST_RX_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !rx_pop) |=> !rx_ready); // R6
endmodule

// File: tb/tb_mbx_host_mailbox.sv
module tb_mbx_host_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_valid, rx_ready;
    logic        tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_byte;
    logic [7:0]  rx_byte = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mbx_host_mailbox dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte)
    );

    // {wr, addr, data-or-expected}
    localparam logic [37:0] VEC [11] = '{
        {1'b0, 5'h08, 32'h3},        // R1 R11
        {1'b0, 5'h00, 32'h0},        // R1
        {1'b0, 5'h04, 32'h0},        // R5
        {1'b1, 5'h00, 32'hF0},       // R8
        {1'b0, 5'h00, 32'hF0},       // R8
        {1'b1, 5'h0C, 32'hFFFFFFFF}, // R10
        {1'b0, 5'h0C, 32'h0},        // R10
        {1'b0, 5'h1C, 32'h0},        // R10
        {1'b0, 5'h08, 32'h3},        // R10
        {1'b1, 5'h00, 32'h0},        // R8
        {1'b0, 5'h00, 32'h0}         // R8
    };
    localparam int VEC_REQ [11] = '{1, 1, 5, 8, 8, 10, 10, 10, 10, 8, 8};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

        for (int i = 0; i < 11; i++) begin
            if (VEC[i][37]) wr(VEC[i][36:32], VEC[i][31:0]);
            else begin
                rd(VEC[i][36:32], d);
                chk($sformatf("R%0d vector %0d", VEC_REQ[i], i), d, VEC[i][31:0]);
            end
        end

        // transmit path, full queue, hold while not ready
        for (int i = 0; i < 8; i++) wr(5'h04, {16'h0, 8'h10 + 8'(i), 8'hA5});
        wr(5'h04, 32'h9900);
        rd_chk("R3 status full", 5'h08, 32'h0);
        chk("R2 first byte", {24'b0, tx_byte}, 32'h10);
        repeat (3) @(negedge clk);
        chk("R2 held byte", {24'b0, tx_byte}, 32'h10);
        chk("R2 held valid", {31'b0, tx_valid}, 32'h1);
        tx_ready = 1'b1;
        #2 chk("R2 order 0", {24'b0, tx_byte}, 32'h10);
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            chk($sformatf("R2 order %0d", i), {24'b0, tx_byte}, 32'h10 + i);
        end
        @(negedge clk);
        chk("R3 ninth dropped", {31'b0, tx_valid}, 32'h0);
        tx_ready = 1'b0;
        rd_chk("R8 tx requests", 5'h00, 32'h03);
        wr(5'h00, 32'h03);
        rd_chk("R8 w1c via irq reg", 5'h00, 32'h00);

        // interrupt line
        wr(5'h00, 32'h10);
        chk("R9 masked no req", {31'b0, irq}, 32'h0);
        wr(5'h04, 32'h7700);
        tx_ready = 1'b1;
        repeat (4) @(negedge clk);
        tx_ready = 1'b0;
        chk("R9 irq raised", {31'b0, irq}, 32'h1);
        rd_chk("R9 irq reg", 5'h00, 32'h11);
        wr(5'h08, 32'h1);
        chk("R7 irq dropped", {31'b0, irq}, 32'h0);
        rd_chk("R7 req0 cleared", 5'h00, 32'h10);
        wr(5'h00, 32'h00);

        // receive path
        rx_send(8'h41);
        rx_send(8'h42);
        rd_chk("R11 rx status", 5'h08, 32'h7);
        rd_chk("R4 rx first", 5'h04, 32'h4100);
        rd_chk("R4 rx second", 5'h04, 32'h4200);
        rd_chk("R5 empty read", 5'h04, 32'h0);
        rd_chk("R5 status unchanged", 5'h08, 32'h3);
        rd_chk("R8 rx request", 5'h00, 32'h04);
        wr(5'h00, 32'h04);

        // overflow
        for (int i = 0; i < 9; i++) rx_send(8'h50 + 8'(i));
        chk("R6 rx_ready full", {31'b0, rx_ready}, 32'h0);
        rd_chk("R6 status ovf", 5'h08, 32'hF);
        rd_chk("R6 ovf request", 5'h00, 32'h0C);
        for (int i = 0; i < 8; i++)
            rd_chk($sformatf("R6 drain %0d", i), 5'h04, {16'h0, 8'h50 + 8'(i), 8'h0});
        rd_chk("R6 discarded", 5'h04, 32'h0);
        rd_chk("R6 sticky", 5'h08, 32'hB);
        wr(5'h08, 32'h0);
        rd_chk("R7 zero no effect", 5'h08, 32'hB);
        wr(5'h08, 32'hB);
        rd_chk("R7 ovf cleared", 5'h08, 32'h3);
        rd_chk("R7 req2 kept", 5'h00, 32'h04);
        wr(5'h00, 32'h04);

        // overflow and its clear on the same edge
        for (int i = 0; i < 9; i++) rx_send(8'h70 + 8'(i));
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'hEE;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h8;
        @(negedge clk);
        rx_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd_chk("R7 set beats clear", 5'h08, 32'hF);
        wr(5'h08, 32'h8);
        rd_chk("R7 clear alone", 5'h08, 32'h7);
        for (int i = 0; i < 8; i++) rd(5'h04, d);

        // take and removal on the same edge
        rx_send(8'h61);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h62;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h04;
        #2 d = bus_rdata;
        @(negedge clk);
        rx_valid = 1'b0; bus_sel = 1'b0;
        chk("R4 pop with push", d, 32'h6100);
        rd_chk("R4 pushed byte", 5'h04, 32'h6200);
        rd_chk("R5 empty after", 5'h04, 32'h0);

        finish_run();
    end
endmodule